// File: doc/BRIEF.md
# Character Display Controller Host Register Port

This block is the host-facing register port of a character display controller. A host drives one access per clock through an enable strobe, a register-select bit, a read/write bit and an 8-bit write bus. Select low addresses the command side. A write there is decoded as a command. A read there returns a status byte with the busy flag on bit 7 and the 7-bit address counter on bits 6..0. The command register cannot be read back. Select high addresses the data side. Writes store into whichever internal memory the last set-address command chose. Reads return a data register that was filled from that memory ahead of time.

Two behavioural memories sit inside the block. The display memory has 128 bytes and is indexed by the full address counter. The glyph memory has 64 bytes and is indexed by the counter's low six bits. After every data read or data write the address counter steps up by one, and the data register is refilled from the new location. Each accepted command holds the busy flag for a parameterised number of cycles. The blank-screen command uses a longer count. A synchronous power-on sequence keeps the block busy for three cycles once reset is released.

Top module: `chd_hostif`

## Requirements
- R1: A status read (enable=1, select=0, rw=1) returns the busy flag on bit 7 and the address counter on bits 6..0, and changes no state.
- R2: A command byte written to the command side never appears on the read bus; a status read after a set-address command shows only busy and the counter.
- R3: While busy, command writes and data writes are ignored: the counter, the selected memory and both memories keep their contents.
- R4: The shift and set-address commands hold busy for exactly OP_CYCLES status reads after acceptance, blank-screen for CLR_CYCLES (defaults 4 and 12). All other codes do nothing and raise no busy.
- R5: After reset is released, busy reads 1 for exactly POR_CYCLES (3) cycles, the counter is 0 and the display memory is selected.
- R6: Set-address has the form 1 T aaaaaa. It loads the counter with {0, aaaaaa} and selects the glyph memory when T=1 and the display memory when T=0.
- R7: A data write (select=1, rw=0) stores the byte at the counter in the selected memory, then increments the counter modulo 128.
- R8: A data read (select=1, rw=1) returns the data register, which holds the selected memory at the counter. The counter then increments and the register is reloaded from the new location.
- R9: Code 0x01 (blank-screen) fills all display memory with 0x20, clears the counter, selects the display memory and leaves glyph memory untouched.
- R10: Code 0x11 increments and code 0x10 decrements the counter, modulo 128.
- R11: Glyph memory accesses use counter bits 5..0, so counter 64 aliases glyph entry 0. Glyph writes do not disturb display memory.
- R12: With enable low the read bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | One-cycle access strobe |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, zero when idle |

## Verification
The assertions assume the host makes at most one access per clock. They also assume the strobe and select inputs are stable, known values while reset is low. The bench drives every input on the falling edge and holds it for one full cycle. It raises the strobe for exactly one cycle per access and releases reset only after several clocks. Data reads during busy windows are not issued, so data-register checks depend only on accepted accesses.

// File: rtl/chd_pkg.sv
package chd_pkg;

    localparam int DW  = 8;
    localparam int ACW = DW - 1;

    localparam logic [DW-1:0] CMD_BLANK    = 8'h01;
    localparam logic [DW-1:0] CMD_STEP_DN  = 8'h10;
    localparam logic [DW-1:0] CMD_STEP_UP  = 8'h11;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_BLANK,
        OP_STEP,
        OP_SETADDR
    } op_e;

    typedef enum logic {
        SPACE_DISP  = 1'b0,
        SPACE_GLYPH = 1'b1
    } space_e;

    typedef struct packed {
        op_e        op;
        logic       up;
        space_e     space;
        logic [5:0] addr;
    } cmd_t;

    typedef struct packed {
        logic status_rd;
        logic data_rd;
        logic data_wr;
        logic cmd_wr;
    } access_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] code);
        cmd_t c;
        c.op    = OP_NOP;
        c.up    = code[0];
        c.space = code[6] ? SPACE_GLYPH : SPACE_DISP;
        c.addr  = code[5:0];
        if (code[7])
            c.op = OP_SETADDR;
        else if (code == CMD_BLANK)
            c.op = OP_BLANK;
        else if (code[7:1] == CMD_STEP_DN[7:1])
            c.op = OP_STEP;
        return c;
    endfunction

    function automatic logic [ACW-1:0] step_ac(input logic [ACW-1:0] ac, input logic up);
        return up ? ac + 1'b1 : ac - 1'b1;
    endfunction

endpackage

// File: rtl/chd_bus_decode.sv
module chd_bus_decode
    import chd_pkg::*;
(
    input  logic    en,
    input  logic    rs,
    input  logic    rw,
    input  logic    busy,
    output access_t acc
);
    always_comb begin
        acc = '0;
        if (en) begin
            if (!rs && rw) begin
                acc.status_rd = 1'b1;
            end else if (!busy) begin
                acc.data_rd = rs & rw;
                acc.data_wr = rs & ~rw;
                acc.cmd_wr  = ~rs & ~rw;
            end
        end
    end
endmodule

// File: rtl/chd_busy_timer.sv
module chd_busy_timer #(
    parameter int OP_CYCLES  = 4,
    parameter int CLR_CYCLES = 12,
    parameter int POR_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_op,
    input  logic start_clr,
    output logic busy
);
    localparam int MAXC = (CLR_CYCLES > OP_CYCLES) ? CLR_CYCLES : OP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int PW   = $clog2(POR_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] por_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q <= PW'(POR_CYCLES);
        end else if (por_q != '0) begin
            por_q <= por_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_clr) begin
            cnt_q <= CW'(CLR_CYCLES);
        end else if (start_op) begin
            cnt_q <= CW'(OP_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0) || (por_q != '0);

    assert_por_busy_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAXC));

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (start_op || start_clr) |=> busy);
endmodule

// File: rtl/chd_ram.sv
module chd_ram #(
    parameter int             AW   = 7,
    parameter int             DW   = 8,
    parameter logic [DW-1:0]  FILL = '0
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          fill,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_fill_ends_R9: assert property (@(posedge clk)
        fill |=> (mem[0] == FILL && mem[DEPTH-1] == FILL));
endmodule

// File: rtl/chd_hostif.sv
module chd_hostif
    import chd_pkg::*;
#(
    parameter int            OP_CYCLES  = 4,
    parameter int            CLR_CYCLES = 12,
    parameter int            POR_CYCLES = 3,
    parameter int            GLYPH_AW   = 6,
    parameter logic [7:0]    BLANK_CHAR = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_en,
    input  logic       bus_rs,
    input  logic       bus_rw,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int DISP_AW = ACW;

    logic           busy;
    access_t        acc;
    cmd_t           cmd;
    logic [ACW-1:0] ac_q, ac_n;
    space_e         sp_q, sp_n;
    logic [DW-1:0]  dr_q, dr_n;
    logic           disp_we, glyph_we, disp_fill;
    logic           st_op, st_clr, dr_load, dr_blank;
    logic [DW-1:0]  disp_rd, glyph_rd;

    chd_bus_decode u_dec (
        .en   (bus_en),
        .rs   (bus_rs),
        .rw   (bus_rw),
        .busy (busy),
        .acc  (acc)
    );

    chd_busy_timer #(
        .OP_CYCLES  (OP_CYCLES),
        .CLR_CYCLES (CLR_CYCLES),
        .POR_CYCLES (POR_CYCLES)
    ) u_busy (
        .clk       (clk),
        .rst       (rst),
        .start_op  (st_op),
        .start_clr (st_clr),
        .busy      (busy)
    );

    assign cmd = decode_cmd(bus_wdata);

    always_comb begin
        ac_n      = ac_q;
        sp_n      = sp_q;
        disp_we   = 1'b0;
        glyph_we  = 1'b0;
        disp_fill = 1'b0;
        st_op     = 1'b0;
        st_clr    = 1'b0;
        dr_load   = 1'b0;
        dr_blank  = 1'b0;
        if (acc.cmd_wr) begin
            case (cmd.op)
                OP_BLANK: begin
                    disp_fill = 1'b1;
                    ac_n      = '0;
                    sp_n      = SPACE_DISP;
                    st_clr    = 1'b1;
                    dr_load   = 1'b1;
                    dr_blank  = 1'b1;
                end
                OP_STEP: begin
                    ac_n    = step_ac(ac_q, cmd.up);
                    st_op   = 1'b1;
                    dr_load = 1'b1;
                end
                OP_SETADDR: begin
                    ac_n    = ACW'(cmd.addr);
                    sp_n    = cmd.space;
                    st_op   = 1'b1;
                    dr_load = 1'b1;
                end
                default: ;
            endcase
        end
        if (acc.data_wr) begin
            disp_we  = (sp_q == SPACE_DISP);
            glyph_we = (sp_q == SPACE_GLYPH);
            ac_n     = step_ac(ac_q, 1'b1);
            dr_load  = 1'b1;
        end
        if (acc.data_rd) begin
            ac_n    = step_ac(ac_q, 1'b1);
            dr_load = 1'b1;
        end
    end

    chd_ram #(.AW(DISP_AW), .DW(DW), .FILL(BLANK_CHAR)) u_disp (
        .clk   (clk),
        .we    (disp_we),
        .waddr (ac_q),
        .wdata (bus_wdata),
        .fill  (disp_fill),
        .raddr (ac_n),
        .rdata (disp_rd)
    );

    chd_ram #(.AW(GLYPH_AW), .DW(DW), .FILL(8'h00)) u_glyph (
        .clk   (clk),
        .we    (glyph_we),
        .waddr (ac_q[GLYPH_AW-1:0]),
        .wdata (bus_wdata),
        .fill  (1'b0),
        .raddr (ac_n[GLYPH_AW-1:0]),
        .rdata (glyph_rd)
    );

    always_comb begin
        if (dr_blank)
            dr_n = BLANK_CHAR;
        else if (sp_n == SPACE_GLYPH)
            dr_n = glyph_rd;
        else
            dr_n = disp_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
            sp_q <= SPACE_DISP;
            dr_q <= '0;
        end else begin
            ac_q <= ac_n;
            sp_q <= sp_n;
            if (dr_load) dr_q <= dr_n;
        end
    end

    always_comb begin
        if (acc.status_rd)
            bus_rdata = {busy, ac_q};
        else if (bus_en && bus_rs && bus_rw)
            bus_rdata = dr_q;
        else
            bus_rdata = '0;
    end

    assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_rw && busy) |=> ($stable(ac_q) && $stable(sp_q)));

    assert_read_steps_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_rs && bus_rw && !busy) |=> (ac_q == ACW'($past(ac_q) + 1'b1)));

    assert_blank_home_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_rs && !bus_rw && !busy && bus_wdata == CMD_BLANK)
            |=> (ac_q == '0 && busy && sp_q == SPACE_DISP));

    assert_status_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_rs && bus_rw && !busy) |=> ($stable(ac_q) && $stable(dr_q)));
endmodule

// File: tb/tb_chd_hostif.sv
`timescale 1ns/1ps
module tb_chd_hostif;
    localparam int OPC = 4;
    localparam int CLC = 12;
    localparam int PORC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0;
    logic       bus_rs = 1'b0;
    logic       bus_rw = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int vecs = 0;
    int bad  = 0;

    logic [7:0] dd_m [128];
    logic [7:0] cg_m [64];
    logic [6:0] ac_m;

    always #2.5 clk = ~clk;

    chd_hostif dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_rs(bus_rs),
        .bus_rw(bus_rw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic rs, input logic rw, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_en = 1'b1; bus_rs = rs; bus_rw = rw; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_rs = 1'b0; bus_rw = 1'b0; bus_wdata = '0;
    endtask

    task automatic count_busy(output int n);
        logic [7:0] r;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            access(1'b0, 1'b1, 8'h00, r);
            if (!r[7]) break;
            n++;
        end
    endtask

    task automatic wait_ready();
        int n;
        count_busy(n);
    endtask

    task automatic cmd(input logic [7:0] c);
        logic [7:0] r;
        access(1'b0, 1'b0, c, r);
    endtask

    function automatic logic [7:0] pat_d(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] pat_g(input int i);
        return 8'((i * 91 + 5) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R5: power-on busy window, counter zero
        count_busy(n);
        check("R5 por busy cycles", n, PORC);
        access(1'b0, 1'b1, 8'h00, r);
        check("R5 counter after reset", r, 8'h00);
        // R12: idle bus reads zero
        @(negedge clk); #1;
        check("R12 idle read bus", bus_rdata, 0);

        // R9/R4: blank-screen then busy length
        cmd(8'h01);
        count_busy(n);
        check("R4 blank busy length", n, CLC);
        for (int i = 0; i < 128; i++) dd_m[i] = 8'h20;

        // R7: fill display memory, counter wraps to 0
        cmd(8'h80); wait_ready();
        for (int i = 0; i < 128; i++) begin
            access(1'b1, 1'b0, pat_d(i), r);
            dd_m[i] = pat_d(i);
        end
        access(1'b0, 1'b1, 8'h00, r);
        check("R7 counter wrap after 128 writes", r, 8'h00);

        // R8: sequential prefetched reads
        cmd(8'h80); wait_ready();
        for (int i = 0; i < 128; i++) begin
            access(1'b1, 1'b1, 8'h00, r);
            check("R8 display read", r, dd_m[i]);
        end
        access(1'b0, 1'b1, 8'h00, r);
        check("R8 counter after reads", r, 8'h00);

        // R11: glyph memory with aliasing at counter 64
        cmd(8'hC0); wait_ready();
        for (int i = 0; i < 64; i++) begin
            access(1'b1, 1'b0, pat_g(i), r);
            cg_m[i] = pat_g(i);
        end
        access(1'b0, 1'b1, 8'h00, r);
        check("R11 counter after glyph writes", r, 64);
        access(1'b1, 1'b0, 8'hE7, r);
        cg_m[0] = 8'hE7;
        cmd(8'hC0); wait_ready();
        for (int i = 0; i < 64; i++) begin
            access(1'b1, 1'b1, 8'h00, r);
            check("R11 glyph read", r, cg_m[i]);
        end
        cmd(8'h85); wait_ready();
        access(1'b1, 1'b1, 8'h00, r);
        check("R11 display untouched by glyph writes", r, dd_m[5]);

        // R6/R2: every set-address value on both memories
        for (int a = 0; a < 64; a++) begin
            cmd(8'(8'h80 | a)); wait_ready();
            access(1'b0, 1'b1, 8'h00, r);
            check("R6 R2 status after display set", r, a);
            access(1'b1, 1'b1, 8'h00, r);
            check("R6 display data at address", r, dd_m[a]);
            cmd(8'(8'hC0 | a)); wait_ready();
            access(1'b1, 1'b1, 8'h00, r);
            check("R6 glyph data at address", r, cg_m[a]);
        end

        // R10: step down wraps, step up
        cmd(8'h80); wait_ready();
        cmd(8'h10);
        count_busy(n);
        check("R4 step busy length", n, OPC);
        access(1'b0, 1'b1, 8'h00, r);
        check("R10 step down wrap", r, 127);
        access(1'b1, 1'b1, 8'h00, r);
        check("R10 data at 127", r, dd_m[127]);
        cmd(8'h11); wait_ready();
        access(1'b0, 1'b1, 8'h00, r);
        check("R10 step up", r, 1);

        // R3: writes during busy are ignored
        cmd(8'h11);
        cmd(8'h89);
        access(1'b1, 1'b0, 8'h5A, r);
        wait_ready();
        access(1'b0, 1'b1, 8'h00, r);
        check("R3 counter unchanged by busy writes", r, 2);
        access(1'b1, 1'b1, 8'h00, r);
        check("R3 memory unchanged by busy write", r, dd_m[2]);

        // R4: unknown code raises no busy and changes nothing
        cmd(8'h02);
        count_busy(n);
        check("R4 unknown code busy", n, 0);
        access(1'b0, 1'b1, 8'h00, r);
        check("R4 unknown code counter", r, 3);

        // R2: command byte is not readable
        cmd(8'h9B); wait_ready();
        access(1'b0, 1'b1, 8'h00, r);
        check("R2 status shows counter not command", r, 8'h1B);

        // R9: blank-screen content, glyph memory kept, busy ignores set
        cmd(8'hC3); wait_ready();
        cmd(8'h01);
        cmd(8'h8A);
        wait_ready();
        access(1'b0, 1'b1, 8'h00, r);
        check("R9 counter home after blank", r, 0);
        for (int i = 0; i < 128; i++) begin
            access(1'b1, 1'b1, 8'h00, r);
            check("R9 display blanked", r, 8'h20);
        end
        cmd(8'hC0); wait_ready();
        access(1'b1, 1'b1, 8'h00, r);
        check("R9 glyph memory kept", r, cg_m[0]);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule